// File: doc/BRIEF.md
# DSP Control and Interrupt Register

This block is the 16-bit control and status word that sits between a host processor and an audio DSP subsystem. It collects interrupt requests from three sources:

- the DSP itself;
- an auxiliary-memory DMA engine;
- an audio DMA engine.

Each source has a status bit, and the enable mask for that source sits in the bit directly above it. When any source has both its status bit and its mask set, the block raises one combined interrupt line to the processor.

Besides the interrupt fields, the word holds four plain control bits: DSP reset, assert-interrupt, halt and init. It also mirrors a busy indication from the auxiliary DMA engine, and that bit cannot be written.

Software reads the whole word on `rd_data` at any time. It writes the word with a one-cycle `wr_en` strobe. A status bit is cleared by writing 1 to it. The DMA engines and the DSP core are outside this block; they appear only as one-cycle event inputs and a busy level. Two further outputs serve the rest of the chip. One is a pulse that tells the audio DMA controller to clear its own control register whenever the DSP reset bit is written as 1. The other is a sticky flag that records any write that put a 1 into the reserved bit positions.

Top module: `dspif_ctrl_reg`

## Requirements
- R1: After a synchronous active-low reset, `rd_data` reads 16'h0004 (only the halt bit, bit 2, is set), and `irq`, `adma_clr` and `pad_err` are 0.
- R2: An event input that is high at a clock edge sets its status bit, and the bit is visible on `rd_data` after that edge. The bit positions are: DSP event at bit 3, auxiliary DMA event at bit 5, audio DMA event at bit 7.
- R3: A write with a 1 in status position 3, 5 or 7 clears that status bit. A write with a 0 there leaves the bit unchanged.
- R4: If an event and a write-one-to-clear hit the same status bit at the same edge, the bit stays set.
- R5: A write loads bit 0 (reset), bit 1 (assert), bit 2 (halt), bit 11 (init) and the mask bits 4, 6 and 8 with the written values.
- R6: `irq` is high exactly when, for at least one source, the status bit and the mask bit directly above it are both 1. In other words, `irq` is high when ((rd_data >> 1) & rd_data & 16'h00A8) is nonzero.
- R7: Bit 9 of `rd_data` shows the value `aux_busy` had at the previous clock edge. Writes never change bit 9.
- R8: A write with bit 0 set makes `adma_clr` high for exactly the one cycle after that write edge. At all other times `adma_clr` is low.
- R9: A write with any 1 in the reserved positions (bits 10 and 12 to 15, mask 16'hF400) sets `pad_err`. Only reset clears `pad_err`. Reserved positions always read 0.
- R10: In a cycle with `wr_en` low and no event, every bit of `rd_data` except bit 9 keeps its value, whatever is on `wr_data`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | One-cycle write strobe for the register word |
| wr_data | input | 16 | Word to write |
| ev_dsp | input | 1 | DSP interrupt event |
| ev_aux | input | 1 | Auxiliary-memory DMA done event |
| ev_audio | input | 1 | Audio DMA block event |
| aux_busy | input | 1 | Auxiliary DMA engine busy level |
| rd_data | output | 16 | Current register word |
| irq | output | 1 | Combined interrupt line to the processor |
| adma_clr | output | 1 | One-cycle pulse that clears the audio DMA control register |
| pad_err | output | 1 | Sticky flag: a write put 1s into reserved bits |

## Verification
The assertions assume that every input is synchronous to `clk` and free of X after reset. They also assume that events and writes are sampled only at rising edges. Under these assumptions, a status bit can be checked for clearing only when no event for the same source arrives at the same edge.

The bench drives all inputs on the falling edge, so each input is stable at the sampling edge. It mixes directed sequences with a long random run. The random run includes simultaneous events and clears, reserved-bit writes and occasional resets. A behavioural model of the word is compared against the outputs after every edge.

// File: rtl/dspif_pkg.sv
// Package: shared layout constants for the DSP control/interrupt word.
// Assumes a 16-bit word with three interrupt sources, each source's mask
// placed immediately above its status bit.
package dspif_pkg;

    localparam int REG_W     = 16;
    localparam int NUM_SRC   = 3;
    localparam int N_CTL     = 4;
    localparam int SRC_BASE  = 3;
    localparam int BIT_BUSY  = 9;
    localparam int BIT_RST   = 0;
    localparam int BIT_HALT  = 2;
    localparam logic [REG_W-1:0] RSV_BITS = 16'hF400;

    // Status bit position of source i (0 = DSP, 1 = aux DMA, 2 = audio DMA).
    function automatic int stat_pos(input int i);
        return SRC_BASE + 2 * i;
    endfunction

    // Mask bit position of source i: directly above its status bit.
    function automatic int mask_pos(input int i);
        return SRC_BASE + 2 * i + 1;
    endfunction

    // Position of plain control bit k: reset, assert, halt, init.
    function automatic int ctl_pos(input int k);
        case (k)
            0:       return 0;
            1:       return 1;
            2:       return 2;
            default: return 11;
        endcase
    endfunction

endpackage

// File: rtl/dspif_src_cell.sv
// Module: one interrupt source slice of the control word: a status bit that
// is set by an event and cleared by writing 1, plus its enable mask.
// Assumes the event input is synchronous to clk; an event beats a clear.
module dspif_src_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_clr,
    input  logic wr_mask,
    input  logic event_in,
    output logic stat_q,
    output logic mask_q,
    output logic req
);

    // Status bit: an event sets it, a written 1 clears it, and the event wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= 1'b0;
        end else if (event_in) begin
            stat_q <= 1'b1;
        end else if (wr_en && wr_clr) begin
            stat_q <= 1'b0;
        end
    end

    // Mask bit: takes the written value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= 1'b0;
        end else if (wr_en) begin
            mask_q <= wr_mask;
        end
    end

    // This source requests an interrupt when it is flagged and enabled.
    assign req = stat_q & mask_q;

endmodule

// File: rtl/dspif_ctl_cell.sv
// Module: one plain read/write control bit with a chosen reset value.
// Assumes writes are single-cycle strobes.
module dspif_ctl_cell #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_bit,
    output logic q
);

    // Load the written value; go to RST_VAL on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= RST_VAL;
        end else if (wr_en) begin
            q <= wr_bit;
        end
    end

endmodule

// File: rtl/dspif_side_regs.sv
// Module: side outputs of the control word: the registered mirror of the
// aux DMA busy level, the audio-DMA clear pulse, and the sticky
// reserved-write flag.
// Assumes aux_busy is synchronous to clk.
module dspif_side_regs #(
    parameter int                 W   = 16,
    parameter logic [W-1:0]       RSV = 16'hF400
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rst_bit,
    input  logic         aux_busy,
    output logic         busy_q,
    output logic         clr_q,
    output logic         err_q
);

    // Mirror the busy level one edge late.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
        end else begin
            busy_q <= aux_busy;
        end
    end

    // Pulse for one cycle after a write that sets the DSP reset bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clr_q <= 1'b0;
        end else begin
            clr_q <= wr_en && rst_bit;
        end
    end

    // Sticky flag for any write with 1s in the reserved positions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else if (wr_en && ((wr_data & RSV) != '0)) begin
            err_q <= 1'b1;
        end
    end

endmodule

// File: rtl/dspif_ctrl_reg.sv
// Module: top of the DSP control/interrupt word. Builds three source
// slices and four control bits, assembles the read word and drives the
// combined interrupt line.
// Assumes single-cycle write strobes; reserved bits are not stored.
module dspif_ctrl_reg
    import dspif_pkg::*;
#(
    parameter int               DATA_W   = REG_W,
    parameter logic [DATA_W-1:0] RSV_MASK = RSV_BITS,
    parameter logic             HALT_RST = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ev_dsp,
    input  logic              ev_aux,
    input  logic              ev_audio,
    input  logic              aux_busy,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq,
    output logic              adma_clr,
    output logic              pad_err
);

    logic [NUM_SRC-1:0] ev_vec;
    logic [NUM_SRC-1:0] stat_q;
    logic [NUM_SRC-1:0] mask_q;
    logic [NUM_SRC-1:0] req_vec;
    logic [N_CTL-1:0]   ctl_q;
    logic               busy_q;
    logic [DATA_W-1:0]  rd_word;

    assign ev_vec = {ev_audio, ev_aux, ev_dsp};

    // One slice per interrupt source.
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        dspif_src_cell u_src (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (wr_en),
            .wr_clr   (wr_data[stat_pos(i)]),
            .wr_mask  (wr_data[mask_pos(i)]),
            .event_in (ev_vec[i]),
            .stat_q   (stat_q[i]),
            .mask_q   (mask_q[i]),
            .req      (req_vec[i])
        );
    end

    // Plain control bits; only halt comes out of reset set.
    for (genvar k = 0; k < N_CTL; k++) begin : g_ctl
        dspif_ctl_cell #(
            .RST_VAL((ctl_pos(k) == BIT_HALT) ? HALT_RST : 1'b0)
        ) u_ctl (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (wr_en),
            .wr_bit (wr_data[ctl_pos(k)]),
            .q      (ctl_q[k])
        );
    end

    dspif_side_regs #(
        .W   (DATA_W),
        .RSV (RSV_MASK)
    ) u_side (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .rst_bit  (wr_data[BIT_RST]),
        .aux_busy (aux_busy),
        .busy_q   (busy_q),
        .clr_q    (adma_clr),
        .err_q    (pad_err)
    );

    // Assemble the read word; reserved positions stay 0.
    always_comb begin
        rd_word = '0;
        for (int k = 0; k < N_CTL; k++) begin
            rd_word[ctl_pos(k)] = ctl_q[k];
        end
        for (int i = 0; i < NUM_SRC; i++) begin
            rd_word[stat_pos(i)] = stat_q[i];
            rd_word[mask_pos(i)] = mask_q[i];
        end
        rd_word[BIT_BUSY] = busy_q;
    end

    assign rd_data = rd_word;

    // Combined interrupt: any source that is flagged and enabled.
    assign irq = |req_vec;

endmodule

// File: rtl/dspif_ctrl_reg_chk.sv
// Module: assertion checker for dspif_ctrl_reg, attached with bind below.
// Assumes inputs are synchronous to clk and known after reset.
module dspif_ctrl_reg_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [15:0] wr_data,
    input logic        ev_dsp,
    input logic        ev_aux,
    input logic        ev_audio,
    input logic        aux_busy,
    input logic [15:0] rd_data,
    input logic        irq,
    input logic        adma_clr,
    input logic        pad_err
);

    // R1
    reset_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (rd_data == 16'h0004 && !pad_err && !adma_clr));

    // R2
    dsp_event_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_dsp |=> rd_data[3]);

    // R2
    audio_event_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_audio |=> rd_data[7]);

    // R3
    aux_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[5] && !ev_aux) |=> !rd_data[5]);

    // R4
    aux_event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_aux && wr_en && wr_data[5]) |=> rd_data[5]);

    // R5
    ctl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rd_data[2] == $past(wr_data[2]) && rd_data[11] == $past(wr_data[11])
                   && rd_data[6] == $past(wr_data[6])));

    // R6
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((rd_data[3] && rd_data[4]) || (rd_data[5] && rd_data[6])
                 || (rd_data[7] && rd_data[8])));

    // R6
    irq_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[7] && rd_data[8]) |-> irq);

    // R7
    busy_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (rd_data[9] == $past(aux_busy)));

    // R8
    clr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[0]) |=> adma_clr);

    // R8
    clr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en || !wr_data[0]) |=> !adma_clr);

    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pad_err |=> pad_err);

    // R9
    rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data & 16'hF400) == 16'h0000);

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !ev_dsp && !ev_aux && !ev_audio) |=>
            ((rd_data & 16'hFDFF) == $past(rd_data & 16'hFDFF)));

endmodule

bind dspif_ctrl_reg dspif_ctrl_reg_chk u_chk (.*);

// File: tb/tb_dspif_ctrl_reg.sv
`timescale 1ns/1ps
// Bench: directed sequences plus a random run, compared every cycle with a
// behavioural model of the control word.
module tb_dspif_ctrl_reg;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = 16'h0;
    logic        ev_dsp = 1'b0, ev_aux = 1'b0, ev_audio = 1'b0, aux_busy = 1'b0;
    logic [15:0] rd_data;
    logic        irq, adma_clr, pad_err;

    int checks = 0;
    int errors = 0;
    bit cmp_on = 1'b0;
    bit done = 1'b0;

    // Model state
    int m_reg = 4;
    bit m_err = 1'b0, m_pulse = 1'b0, m_busy = 1'b0;

    always #2.5 clk = ~clk;

    dspif_ctrl_reg dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .ev_dsp(ev_dsp), .ev_aux(ev_aux), .ev_audio(ev_audio), .aux_busy(aux_busy),
        .rd_data(rd_data), .irq(irq), .adma_clr(adma_clr), .pad_err(pad_err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Behavioural model, stepped on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_reg = 4; m_err = 0; m_pulse = 0; m_busy = 0;
        end else begin
            m_pulse = wr_en && wr_data[0];
            m_busy  = aux_busy;
            if (wr_en) begin
                int ctl_bits[7] = '{0, 1, 2, 4, 6, 8, 11};
                foreach (ctl_bits[j]) begin
                    if (wr_data[ctl_bits[j]]) m_reg = m_reg | (1 << ctl_bits[j]);
                    else                      m_reg = m_reg & ~(1 << ctl_bits[j]);
                end
                if (wr_data[3]) m_reg = m_reg & ~8;
                if (wr_data[5]) m_reg = m_reg & ~32;
                if (wr_data[7]) m_reg = m_reg & ~128;
                if ((wr_data & 16'hF400) != 0) m_err = 1;
            end
            if (ev_dsp)   m_reg = m_reg | 8;
            if (ev_aux)   m_reg = m_reg | 32;
            if (ev_audio) m_reg = m_reg | 128;
        end
    end

    // Compare outputs with the model on every falling edge
    always @(negedge clk) begin
        if (cmp_on && !done) begin
            int exp_rd;
            exp_rd = m_reg | (int'(m_busy) << 9);
            chk("MODEL rd_data", {16'h0, rd_data}, exp_rd[31:0]);
            chk("MODEL irq", {31'h0, irq}, {31'h0, (((m_reg >> 1) & m_reg & 'hA8) != 0)});
            chk("MODEL adma_clr", {31'h0, adma_clr}, {31'h0, m_pulse});
            chk("MODEL pad_err", {31'h0, pad_err}, {31'h0, m_err});
        end
    end

    task automatic step(input bit we, input logic [15:0] d, input bit ed, input bit ea,
                        input bit eu, input bit bz);
        wr_en = we; wr_data = d; ev_dsp = ed; ev_aux = ea; ev_audio = eu; aux_busy = bz;
        @(negedge clk);
        wr_en = 1'b0; wr_data = 16'h0; ev_dsp = 1'b0; ev_aux = 1'b0; ev_audio = 1'b0;
        aux_busy = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #1000000;
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 reset word", {16'h0, rd_data}, 32'h0004);
        chk("R1 reset irq", {31'h0, irq}, 32'h0);
        chk("R1 reset err", {31'h0, pad_err}, 32'h0);
        chk("R1 reset pulse", {31'h0, adma_clr}, 32'h0);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        @(negedge clk);

        // R2 event sets DSP status, masked so no irq
        step(0, 16'h0, 1, 0, 0, 0);
        chk("R2 dsp status set", {16'h0, rd_data}, 32'h000C);
        chk("R6 masked no irq", {31'h0, irq}, 32'h0);

        // R3 writing 0 keeps status; mask on raises irq
        step(1, 16'h0014, 0, 0, 0, 0);
        chk("R3 write0 keeps status", {16'h0, rd_data}, 32'h001C);
        chk("R6 irq on", {31'h0, irq}, 32'h1);

        // R3 writing 1 clears status
        step(1, 16'h001C, 0, 0, 0, 0);
        chk("R3 write1 clears", {16'h0, rd_data}, 32'h0014);
        chk("R6 irq off", {31'h0, irq}, 32'h0);

        // R4 event beats clear on aux bit; audio cleared normally
        step(0, 16'h0, 0, 0, 1, 0);
        step(1, 16'h01E0, 0, 1, 0, 0);
        chk("R4 event wins", {16'h0, rd_data}, 32'h0160);
        chk("R6 aux irq", {31'h0, irq}, 32'h1);

        // R5 control bits load
        step(1, 16'h0806, 0, 0, 0, 0);
        chk("R5 ctl bits", {16'h0, rd_data}, 32'h0826);
        chk("R5 no err for init", {31'h0, pad_err}, 32'h0);

        // R7 busy mirror, not writable
        step(1, 16'h0000, 0, 0, 0, 1);
        chk("R7 busy shown", {16'h0, rd_data}, 32'h0220);
        step(1, 16'h0200, 0, 0, 0, 0);
        chk("R7 busy not writable", {16'h0, rd_data}, 32'h0020);

        // R8 clear pulse
        step(1, 16'h0001, 0, 0, 0, 0);
        chk("R8 pulse high", {31'h0, adma_clr}, 32'h1);
        chk("R8 reset bit stored", {16'h0, rd_data}, 32'h0021);
        step(0, 16'h0, 0, 0, 0, 0);
        chk("R8 pulse one cycle", {31'h0, adma_clr}, 32'h0);

        // R9 reserved write flag, sticky, reads zero
        step(1, 16'h0420, 0, 0, 0, 0);
        chk("R9 err set", {31'h0, pad_err}, 32'h1);
        chk("R9 reserved read zero", {16'h0, rd_data}, 32'h0000);
        step(1, 16'h0000, 0, 0, 0, 0);
        chk("R9 err sticky", {31'h0, pad_err}, 32'h1);

        // R10 data without strobe ignored
        step(1, 16'h0016, 0, 0, 0, 0);
        step(0, 16'hFFFF, 0, 0, 0, 0);
        chk("R10 idle hold", {16'h0, rd_data}, 32'h0016);
        chk("R10 no pulse", {31'h0, adma_clr}, 32'h0);
        step(0, 16'h0, 1, 0, 0, 0);
        chk("R6 dsp irq", {31'h0, irq}, 32'h1);

        // Random run against the model
        for (int n = 0; n < 4000; n++) begin
            logic [15:0] d;
            rst_n = (($urandom % 150) != 0);
            d = (($urandom % 8) == 0) ? 16'($urandom) : (16'($urandom) & 16'h0BFF);
            step(($urandom % 3) == 0, d, ($urandom % 5) == 0, ($urandom % 5) == 0,
                 ($urandom % 5) == 0, ($urandom % 2) == 0);
        end
        rst_n = 1'b1;
        step(1, 16'hF000, 0, 0, 0, 0);

        // R1 reset clears sticky flag
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 reset clears err", {31'h0, pad_err}, 32'h0);
        chk("R1 reset word again", {16'h0, rd_data}, 32'h0004);
        finish_run();
    end

endmodule